// File: doc/BRIEF.md
# LCD Common Scan Sequencer

This block steps a multiplexed dot-matrix LCD through its common electrodes one row slot at a time. For every dot common and for the pictograph commons it gives a 3-bit drive-level code each cycle. A downstream analog stage turns each code into a voltage. A row-clock enable moves the scan forward by one slot. A duty select picks either a full frame of 52 slots or a short frame of 39 slots, and a direction select reverses the order in which the dot commons are visited.

In the short frame, two interior groups of dot commons (20 to 26 and 46 to 51) are never selected and stay at the idle level. The pictograph commons always own the last slot of a frame, and both pictograph outputs carry the same code. Drive polarity flips at each frame boundary, so the select and idle levels alternate over a two-frame AC cycle. A frame-start flag marks the first slot of every frame.

Top module: `lcd_com_seq`

## Requirements
- R1: While reset is asserted, and after it is released before any row advance, the scan is in slot 1 with positive polarity (`neg_pol`=0) and `frame_start`=1. Slot 1 selects dot common 1 in forward order and dot common 51 in reverse order.
- R2: With `duty_low`=0 and `reverse`=0, slots 1 to 51 select dot commons 1 to 51 in ascending order, and a frame has 52 slots.
- R3: With `duty_low`=1, a frame has 39 slots, and the dot slots select commons 1 to 19 and then 27 to 45 in ascending order (forward).
- R4: With `duty_low`=1, dot commons 20 to 26 and 46 to 51 always output the non-selected level for the current polarity.
- R5: The last slot of a frame (slot 52, or slot 39 in short duty) selects the pictograph commons and no dot common. `pcom_a_lvl` and `pcom_b_lvl` are always equal.
- R6: With `reverse`=1, the active dot commons are visited in descending order, and the pictograph slot stays last.
- R7: Level codes run from 0 (highest LCD level) to 5 (ground). In positive polarity the selected common gets 0 and the others get 1. In negative polarity the selected common gets 5 and the others get 4. No other code appears.
- R8: An advance from the last slot returns to slot 1, toggles `neg_pol`, and raises `frame_start`. `frame_start` is 1 exactly in slot 1, and polarity changes only on entry to slot 1.
- R9: A clock edge with `row_en`=0 leaves the slot and the polarity unchanged.
- R10: If the duty is shortened while the scan sits at or beyond the new pictograph slot, that slot drives the pictograph commons. The next advance starts a new frame with toggled polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_en | input | 1 | Advance the scan by one slot on this edge |
| duty_low | input | 1 | 1 selects the 39-slot frame, 0 selects the 52-slot frame |
| reverse | input | 1 | 1 reverses the dot common order |
| com_lvl | output | 153 | Level code of dot common k in bits [3k-1:3k-3] |
| pcom_a_lvl | output | 3 | Level code of the first pictograph common |
| pcom_b_lvl | output | 3 | Level code of the second pictograph common |
| frame_start | output | 1 | High in the first slot of each frame |
| neg_pol | output | 1 | Current polarity, 1 for the negative frame |

## Verification
A wrong slot count shows up on the first row advance: the select code appears on the wrong common, or on the pictograph pair one slot too early or too late. A wrong polarity bit swaps every code on all 53 outputs at the same moment, so one sample shows it. A wrap fault, such as a missed toggle or the wrong frame length, shows within one frame through `frame_start` and `neg_pol`. The idle groups of the short frame are compared on every sample taken in that mode.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  // Six drive levels: 0 is the highest LCD level, 5 is ground.
  localparam lvl_t LVL_TOP = 3'd0;
  localparam lvl_t LVL_HI  = 3'd1;
  localparam lvl_t LVL_LO  = 3'd4;
  localparam lvl_t LVL_GND = 3'd5;

  function automatic lvl_t drive_lvl(input logic sel, input logic neg);
    if (sel) return neg ? LVL_GND : LVL_TOP;
    return neg ? LVL_LO : LVL_HI;
  endfunction
endpackage

// File: rtl/lcd_slot_ctr.sv
module lcd_slot_ctr #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_en,
  input  logic [SLOT_W-1:0] last_slot,
  output logic [SLOT_W-1:0] slot,
  output logic              neg_pol
);
  logic [SLOT_W-1:0] slot_d;
  logic              pol_d;

  always_comb begin
    slot_d = slot;
    pol_d  = neg_pol;
    if (row_en) begin
      if (slot >= last_slot) begin
        slot_d = '0;
        pol_d  = ~neg_pol;
      end else begin
        slot_d = slot + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= '0;
      neg_pol <= 1'b0;
    end else begin
      slot    <= slot_d;
      neg_pol <= pol_d;
    end
  end
endmodule

// File: rtl/lcd_slot_map.sv
module lcd_slot_map #(
  parameter int NUM_COM = 51,
  parameter int SEG_A   = 19,
  parameter int GAP_A   = 7,
  parameter int SEG_B   = 19,
  parameter int SLOT_W  = 6
) (
  input  logic [SLOT_W-1:0]  slot,
  input  logic               duty_low,
  input  logic               reverse,
  output logic [SLOT_W-1:0]  last_slot,
  output logic [NUM_COM-1:0] sel_dot,
  output logic               sel_pict
);
  localparam int NDOT_LOW = SEG_A + SEG_B;
  localparam int IDX_W    = $clog2(NUM_COM + GAP_A + 1) + 1;

  logic [IDX_W-1:0] ndot, slot_x, pos, com_idx;

  always_comb begin
    ndot     = duty_low ? IDX_W'(NDOT_LOW) : IDX_W'(NUM_COM);
    slot_x   = IDX_W'(slot);
    sel_pict = (slot_x >= ndot);
    pos      = reverse ? (ndot - IDX_W'(1) - slot_x) : slot_x;
    com_idx  = (duty_low && (pos >= IDX_W'(SEG_A))) ? pos + IDX_W'(GAP_A) : pos;
    last_slot = ndot[SLOT_W-1:0];
  end

  for (genvar i = 0; i < NUM_COM; i++) begin : g_sel
    assign sel_dot[i] = !sel_pict && (com_idx == IDX_W'(i));
  end
endmodule

// File: rtl/lcd_level_drv.sv
module lcd_level_drv
  import lcd_com_pkg::*;
#(
  parameter int NUM_COM = 51
) (
  input  logic [NUM_COM-1:0]       sel_dot,
  input  logic                     sel_pict,
  input  logic                     neg_pol,
  output logic [NUM_COM*LVL_W-1:0] com_lvl,
  output logic [LVL_W-1:0]         pict_lvl
);
  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    assign com_lvl[i*LVL_W +: LVL_W] = drive_lvl(sel_dot[i], neg_pol);
  end
  assign pict_lvl = drive_lvl(sel_pict, neg_pol);
endmodule

// File: rtl/lcd_com_seq.sv
module lcd_com_seq
  import lcd_com_pkg::*;
#(
  parameter int NUM_COM = 51,
  parameter int SEG_A   = 19,
  parameter int GAP_A   = 7,
  parameter int SEG_B   = 19
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     row_en,
  input  logic                     duty_low,
  input  logic                     reverse,
  output logic [NUM_COM*LVL_W-1:0] com_lvl,
  output logic [LVL_W-1:0]         pcom_a_lvl,
  output logic [LVL_W-1:0]         pcom_b_lvl,
  output logic                     frame_start,
  output logic                     neg_pol
);
  localparam int SLOT_W = $clog2(NUM_COM + 1);

  logic              rst_meta, rst_sync;
  logic [SLOT_W-1:0] slot, last_slot;
  logic [NUM_COM-1:0] sel_dot;
  logic              sel_pict;
  logic [LVL_W-1:0]  pict_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  lcd_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst_n(rst_sync), .row_en(row_en),
    .last_slot(last_slot), .slot(slot), .neg_pol(neg_pol)
  );

  lcd_slot_map #(
    .NUM_COM(NUM_COM), .SEG_A(SEG_A), .GAP_A(GAP_A), .SEG_B(SEG_B), .SLOT_W(SLOT_W)
  ) u_map (
    .slot(slot), .duty_low(duty_low), .reverse(reverse),
    .last_slot(last_slot), .sel_dot(sel_dot), .sel_pict(sel_pict)
  );

  lcd_level_drv #(.NUM_COM(NUM_COM)) u_drv (
    .sel_dot(sel_dot), .sel_pict(sel_pict), .neg_pol(neg_pol),
    .com_lvl(com_lvl), .pict_lvl(pict_lvl)
  );

  assign pcom_a_lvl  = pict_lvl;
  assign pcom_b_lvl  = pict_lvl;
  assign frame_start = (slot == '0);
endmodule

// File: rtl/lcd_com_seq_chk.sv
module lcd_com_seq_chk #(
  parameter int NUM_COM = 51,
  parameter int SEG_A   = 19,
  parameter int GAP_A   = 7,
  parameter int SEG_B   = 19
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   row_en,
  input logic                   duty_low,
  input logic [NUM_COM*3-1:0]   com_lvl,
  input logic [2:0]             pcom_a_lvl,
  input logic [2:0]             pcom_b_lvl,
  input logic                   frame_start,
  input logic                   neg_pol
);
  logic [NUM_COM-1:0] sel_vec, legal_vec, idle_ok;
  logic [2:0]         idle_code;
  logic               pict_sel;

  assign idle_code = neg_pol ? 3'd4 : 3'd1;
  assign pict_sel  = (pcom_a_lvl == 3'd0) || (pcom_a_lvl == 3'd5);

  for (genvar i = 0; i < NUM_COM; i++) begin : g_c
    localparam int C = i + 1;
    localparam bit GAP = ((C > SEG_A) && (C <= SEG_A + GAP_A)) || (C > SEG_A + GAP_A + SEG_B);
    logic [2:0] v;
    assign v            = com_lvl[i*3 +: 3];
    assign sel_vec[i]   = (v == 3'd0) || (v == 3'd5);
    assign legal_vec[i] = (v == 3'd0) || (v == 3'd1) || (v == 3'd4) || (v == 3'd5);
    assign idle_ok[i]   = !GAP || (v == idle_code);
  end

  p_one_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sel_vec, pict_sel}));
  p_pict_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pcom_a_lvl == pcom_b_lvl);
  p_gap_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    duty_low |-> (&idle_ok));
  p_legal_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    &legal_vec);
  p_pol_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(neg_pol) |-> frame_start);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !row_en |=> ($stable(neg_pol) && $stable(frame_start)));
endmodule

bind lcd_com_seq lcd_com_seq_chk #(
  .NUM_COM(NUM_COM), .SEG_A(SEG_A), .GAP_A(GAP_A), .SEG_B(SEG_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .row_en(row_en), .duty_low(duty_low),
  .com_lvl(com_lvl), .pcom_a_lvl(pcom_a_lvl), .pcom_b_lvl(pcom_b_lvl),
  .frame_start(frame_start), .neg_pol(neg_pol)
);

// File: tb/lcd_com_seq_bench.sv
`timescale 1ns/1ps
module lcd_com_seq_bench;
  localparam int NC = 51;

  logic clk = 1'b0;
  logic rst_n, row_en, duty_low, reverse;
  logic [NC*3-1:0] com_lvl;
  logic [2:0] pcom_a_lvl, pcom_b_lvl;
  logic frame_start, neg_pol;

  always #2 clk = ~clk;

  lcd_com_seq u_lcd_com_seq (
    .clk(clk), .rst_n(rst_n), .row_en(row_en), .duty_low(duty_low), .reverse(reverse),
    .com_lvl(com_lvl), .pcom_a_lvl(pcom_a_lvl), .pcom_b_lvl(pcom_b_lvl),
    .frame_start(frame_start), .neg_pol(neg_pol)
  );

  typedef struct {
    int    sel;
    bit    pol;
    bit    fs;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    exp_slot;
  bit    exp_pol, m_low, m_rev, done;
  int    checks, errors;

  function automatic int nslots(bit low);
    return low ? 39 : 52;
  endfunction

  // Ordered list of active dot commons; 0 means the pictograph slot.
  function automatic int pick(int s, bit low, bit rev);
    int ord[$];
    for (int c = 1; c <= NC; c++)
      if (!low || c <= 19 || (c >= 27 && c <= 45)) ord.push_back(c);
    if (rev) ord.reverse();
    if (s < ord.size()) return ord[s];
    return 0;
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.sel = pick(exp_slot, m_low, m_rev);
    e.pol = exp_pol;
    e.fs  = (exp_slot == 0);
    e.tag = tag;
    if (tag != "R10" && tag != "R1" && tag != "R9") begin
      if (exp_slot == 0) e.tag = "R8";
      else if (e.sel == 0) e.tag = "R5";
    end
    sb.push_back(e);
  endtask

  task automatic step(string tag);
    @(negedge clk);
    row_en = 1'b1;
    @(posedge clk);
    #1;
    row_en = 1'b0;
    if (exp_slot >= nslots(m_low) - 1) begin
      exp_slot = 0;
      exp_pol  = ~exp_pol;
    end else begin
      exp_slot++;
    end
    push(tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    row_en = 1'b0;
    @(posedge clk);
    #1;
    push(tag);
  endtask

  task automatic set_mode(bit low, bit rev, string tag);
    @(negedge clk);
    duty_low = low;
    reverse  = rev;
    m_low    = low;
    m_rev    = rev;
    #1;
    push(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    row_en   = 1'b0;
    exp_slot = 0;
    exp_pol  = 1'b0;
    @(negedge clk);
    #1;
    push("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    push("R1");
  endtask

  // Monitor: pop expected items and compare against the outputs.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        logic [NC*3-1:0] ev;
        logic [2:0] ep;
        e = sb.pop_front();
        for (int c = 1; c <= NC; c++)
          ev[(c-1)*3 +: 3] = (c == e.sel) ? (e.pol ? 3'd5 : 3'd0) : (e.pol ? 3'd4 : 3'd1);
        ep = (e.sel == 0) ? (e.pol ? 3'd5 : 3'd0) : (e.pol ? 3'd4 : 3'd1);
        checks++;
        if (com_lvl !== ev || pcom_a_lvl !== ep || pcom_b_lvl !== ep ||
            frame_start !== e.fs || neg_pol !== e.pol) begin
          errors++;
          $display("FAIL %s: com=%h pa=%0d pb=%0d fs=%b pol=%b expected com=%h p=%0d fs=%b pol=%b",
                   e.tag, com_lvl, pcom_a_lvl, pcom_b_lvl, frame_start, neg_pol,
                   ev, ep, e.fs, e.pol);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired, expected run to complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    done = 1'b0; checks = 0; errors = 0;
    rst_n = 1'b0; row_en = 1'b0; duty_low = 1'b0; reverse = 1'b0;
    m_low = 1'b0; m_rev = 1'b0; exp_slot = 0; exp_pol = 1'b0;
    do_reset();                                         // R1
    for (int i = 0; i < 52; i++) step("R2");            // positive frame, wrap R8
    for (int i = 0; i < 52; i++) step("R7");            // negative frame levels
    for (int i = 0; i < 3; i++) step("R2");
    for (int i = 0; i < 4; i++) idle("R9");             // hold without row_en
    step("R2");
    while (exp_slot != 0) step("R2");
    set_mode(1'b1, 1'b0, "R3");
    for (int i = 0; i < 39; i++) step("R3");            // short frame, forward
    for (int i = 0; i < 39; i++) step("R4");            // idle groups, other polarity
    set_mode(1'b1, 1'b1, "R6");
    for (int i = 0; i < 39; i++) step("R6");            // reverse short frame
    set_mode(1'b0, 1'b1, "R6");
    for (int i = 0; i < 52; i++) step("R6");            // reverse full frame
    set_mode(1'b0, 1'b0, "R2");
    for (int i = 0; i < 45; i++) step("R2");
    set_mode(1'b1, 1'b0, "R10");                        // shorten beyond slot
    step("R10");                                        // wraps, toggles
    step("R3");
    set_mode(1'b0, 1'b1, "R6");
    for (int i = 0; i < 5; i++) step("R6");
    do_reset();                                         // R1 in reverse order
    step("R6");
    wait (sb.size() == 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule